// File: doc/BRIEF.md
# Condition Register Field Unit

This block keeps a 32-bit condition register split into eight 4-bit fields and updates it one command at a time. A compare command orders two 32-bit operands, either signed or unsigned. The second operand is a register value or a 16-bit immediate. The result is written as a 4-bit code into a chosen field, and the lowest bit of that field copies the summary-overflow flag supplied with the command.

Other commands do the following:
- Combine two single condition bits with one of eight boolean functions and write the result to a third bit.
- Copy one whole field into another.
- Overwrite any set of nibbles from a general register under an 8-bit mask.

The full register is always visible on a registered output, so a read is simply sampling that output. Field 0 is the most significant nibble. Bit index i names physical bit 31-i.

Top module: `cond_field_unit`

## Requirements
- R1: Synchronous active-high `rst` clears the register to 0 at the next rising edge. `cr_q` always presents all 32 register bits unchanged.
- R2: A compare (op 1 to 4) writes a nibble to field d, at bits 31-4d down to 28-4d. The nibble is 4'b1000 for less, 4'b0100 for greater and 4'b0010 for equal, and its bit 0 copies `so_in`. Exactly one of its top three bits is set. Other fields are kept.
- R3: Op 1 compares `opnd_a` against `opnd_b` as 32-bit two's-complement values.
- R4: Op 2 compares `opnd_a` against `opnd_b` as unsigned values.
- R5: Op 3 compares `opnd_a` against `imm16` sign-extended, as signed values. Op 4 compares against `imm16` zero-extended, as unsigned values.
- R6: Op 5 reads physical bits 31-`bit_a` and 31-`bit_b` and writes the result to physical bit 31-`bit_t`. All other bits are kept.
- R7: For op 5, `bool_fn` selects the function of the two bits x and y: 0 AND, 1 OR, 2 NAND, 3 XOR, 4 NOR, 5 XNOR, 6 x AND NOT y, 7 x OR NOT y.
- R8: Op 6 copies the nibble of field `fld_src` into field `fld_dst`. A copy onto the same field leaves the register unchanged.
- R9: Op 7 takes an 8-bit mask. Mask bit i loads physical bits 4i+3 down to 4i from `opnd_a`, and nibbles whose mask bit is clear keep their value. A zero mask changes nothing.
- R10: When `cmd_valid` is low, or when the op is 0 or in the range 8 to 15, the register is unchanged. All updates land on the rising edge that samples the valid command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| opnd_a | input | 32 | First compare operand, or source for the masked write |
| opnd_b | input | 32 | Second compare operand for register compares |
| imm16 | input | 16 | Immediate compare operand |
| so_in | input | 1 | Summary-overflow flag copied into compare results |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index for a field copy |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_t | input | 5 | Target bit index |
| bool_fn | input | 3 | Boolean function select |
| fld_mask | input | 8 | Nibble enable mask |
| cr_q | output | 32 | Full condition register |

## Verification
The compare path is driven with operand pairs that get opposite orderings under signed and unsigned rules: all-ones against one, and zero against the most negative value. This separates a signed compare from an unsigned one. An immediate of 0xFFFB, and then 0xFFFF, is used with both immediate compares to separate sign extension from zero extension. The eight bit functions are each driven from a known register state, with source bits chosen so that the result flips the target bit wherever possible. Wrong bit addressing or a wrong truth table therefore shows up as a changed value. Field copies, partial and empty masks, unused opcodes and idle cycles check that untouched nibbles keep their value.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int CFU_FIELDS = 8;
  localparam int CFU_NIB    = 4;
  localparam int CFU_WIDTH  = CFU_FIELDS * CFU_NIB;
  localparam int CFU_FLDW   = $clog2(CFU_FIELDS);
  localparam int CFU_BITW   = $clog2(CFU_WIDTH);
  localparam int CFU_IMMW   = 16;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CMP_S  = 4'd1,
    OP_CMP_U  = 4'd2,
    OP_CMPI_S = 4'd3,
    OP_CMPI_U = 4'd4,
    OP_BITOP  = 4'd5,
    OP_FMOVE  = 4'd6,
    OP_MASKWR = 4'd7
  } cfu_op_e;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_NAND = 3'd2,
    FN_XOR  = 3'd3,
    FN_NOR  = 3'd4,
    FN_EQV  = 3'd5,
    FN_ANDC = 3'd6,
    FN_ORC  = 3'd7
  } cfu_fn_e;
endpackage

// File: rtl/cfu_compare.sv
module cfu_compare
  import cfu_pkg::*;
#(
  parameter int W = CFU_WIDTH
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         signed_mode,
  input  logic         so,
  output logic [3:0]   code
);
  logic lhs_x, rhs_x;
  logic lt, eq;

  always_comb begin
    lhs_x = signed_mode & lhs[W-1];
    rhs_x = signed_mode & rhs[W-1];
    eq    = (lhs == rhs);
    lt    = $signed({lhs_x, lhs}) < $signed({rhs_x, rhs});
    code  = {lt, ~lt & ~eq, eq, so};
  end
endmodule

// File: rtl/cfu_bitop.sv
module cfu_bitop
  import cfu_pkg::*;
(
  input  logic    x,
  input  logic    y,
  input  cfu_fn_e fn,
  output logic    r
);
  always_comb begin
    unique case (fn)
      FN_AND:  r = x & y;
      FN_OR:   r = x | y;
      FN_NAND: r = ~(x & y);
      FN_XOR:  r = x ^ y;
      FN_NOR:  r = ~(x | y);
      FN_EQV:  r = ~(x ^ y);
      FN_ANDC: r = x & ~y;
      FN_ORC:  r = x | ~y;
      default: r = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfu_mask_expand.sv
module cfu_mask_expand
  import cfu_pkg::*;
#(
  parameter int FIELDS = CFU_FIELDS,
  parameter int NIB    = CFU_NIB
) (
  input  logic [FIELDS-1:0]     mask,
  output logic [FIELDS*NIB-1:0] bit_en
);
  for (genvar g = 0; g < FIELDS; g++) begin : g_nib
    assign bit_en[g*NIB +: NIB] = {NIB{mask[g]}};
  end
endmodule

// File: rtl/cond_field_unit.sv
module cond_field_unit
  import cfu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [3:0]          cmd_op,
  input  logic [CFU_WIDTH-1:0] opnd_a,
  input  logic [CFU_WIDTH-1:0] opnd_b,
  input  logic [CFU_IMMW-1:0] imm16,
  input  logic                so_in,
  input  logic [CFU_FLDW-1:0] fld_dst,
  input  logic [CFU_FLDW-1:0] fld_src,
  input  logic [CFU_BITW-1:0] bit_a,
  input  logic [CFU_BITW-1:0] bit_b,
  input  logic [CFU_BITW-1:0] bit_t,
  input  logic [2:0]          bool_fn,
  input  logic [CFU_FIELDS-1:0] fld_mask,
  output logic [CFU_WIDTH-1:0] cr_q
);
  localparam int W = CFU_WIDTH;

  logic [W-1:0]        cr_r, cr_nxt;
  logic [W-1:0]        cmp_rhs, imm_ext, bit_en;
  logic                cmp_signed;
  logic [3:0]          cmp_code;
  logic                bit_x, bit_y, bit_r;
  logic [CFU_BITW-1:0] dst_lsb, src_lsb, pa, pb, pt;
  cfu_op_e             op;

  assign op = cfu_op_e'(cmd_op);

  always_comb begin
    dst_lsb = CFU_BITW'((CFU_FIELDS - 1 - int'(fld_dst)) * CFU_NIB);
    src_lsb = CFU_BITW'((CFU_FIELDS - 1 - int'(fld_src)) * CFU_NIB);
    pa      = CFU_BITW'(W - 1 - int'(bit_a));
    pb      = CFU_BITW'(W - 1 - int'(bit_b));
    pt      = CFU_BITW'(W - 1 - int'(bit_t));
    bit_x   = cr_r[pa];
    bit_y   = cr_r[pb];
  end

  always_comb begin
    cmp_signed = (op == OP_CMP_S) || (op == OP_CMPI_S);
    imm_ext    = cmp_signed ? {{(W-CFU_IMMW){imm16[CFU_IMMW-1]}}, imm16}
                            : {{(W-CFU_IMMW){1'b0}}, imm16};
    cmp_rhs    = ((op == OP_CMPI_S) || (op == OP_CMPI_U)) ? imm_ext : opnd_b;
  end

  cfu_compare #(.W(W)) u_cmp (
    .lhs(opnd_a), .rhs(cmp_rhs), .signed_mode(cmp_signed),
    .so(so_in), .code(cmp_code)
  );

  cfu_bitop u_bit (
    .x(bit_x), .y(bit_y), .fn(cfu_fn_e'(bool_fn)), .r(bit_r)
  );

  cfu_mask_expand #(.FIELDS(CFU_FIELDS), .NIB(CFU_NIB)) u_mask (
    .mask(fld_mask), .bit_en(bit_en)
  );

  always_comb begin
    cr_nxt = cr_r;
    if (cmd_valid) begin
      case (op)
        OP_CMP_S, OP_CMP_U, OP_CMPI_S, OP_CMPI_U:
          cr_nxt[dst_lsb +: CFU_NIB] = cmp_code;
        OP_BITOP:
          cr_nxt[pt] = bit_r;
        OP_FMOVE:
          cr_nxt[dst_lsb +: CFU_NIB] = cr_r[src_lsb +: CFU_NIB];
        OP_MASKWR:
          cr_nxt = (opnd_a & bit_en) | (cr_r & ~bit_en);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cr_r <= '0;
    else     cr_r <= cr_nxt;
  end

  assign cr_q = cr_r;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker
  import cfu_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  cmd_valid,
  input logic [3:0]            cmd_op,
  input logic                  so_in,
  input logic [CFU_FLDW-1:0]   fld_dst,
  input logic [CFU_FLDW-1:0]   fld_src,
  input logic [CFU_FIELDS-1:0] fld_mask,
  input logic [CFU_WIDTH-1:0]  cr_q
);
  logic                rst_d, so_d;
  logic [CFU_FLDW-1:0] dst_d, src_d;
  logic [CFU_WIDTH-1:0] cr_d;
  logic [3:0]          dst_nib, src_nib_prev;
  logic                is_cmp;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    so_d  <= so_in;
    dst_d <= fld_dst;
    src_d <= fld_src;
    cr_d  <= cr_q;
  end

  always_comb begin
    dst_nib      = 4'(cr_q >> ((CFU_FIELDS - 1 - int'(dst_d)) * CFU_NIB));
    src_nib_prev = 4'(cr_d >> ((CFU_FIELDS - 1 - int'(src_d)) * CFU_NIB));
    is_cmp       = (cmd_op >= 4'd1) && (cmd_op <= 4'd4);
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> cr_q == '0); // R1
  AST_CMP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_cmp) |=> $countones(dst_nib[3:1]) == 1); // R2
  AST_CMP_SO_COPY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_cmp) |=> dst_nib[0] == so_d); // R2
  AST_FMOVE_COPY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 4'd6) |=> dst_nib == src_nib_prev); // R8
  AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 4'd7 && fld_mask == '0) |=> $stable(cr_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid) |=> $stable(cr_q)); // R10
endmodule

bind cond_field_unit cfu_checker u_chk (.*);

// File: tb/tb_cond_field_unit.sv
module tb_cond_field_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic        so_in = 1'b0;
  logic [2:0]  fld_dst = '0, fld_src = '0, bool_fn = '0;
  logic [4:0]  bit_a = '0, bit_b = '0, bit_t = '0;
  logic [7:0]  fld_mask = '0;
  logic [31:0] cr_q;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cond_field_unit dut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic        so;
    logic [2:0]  dst;
    logic [2:0]  src;
    logic [4:0]  ba;
    logic [4:0]  bb;
    logic [4:0]  bt;
    logic [2:0]  fn;
    logic [7:0]  mask;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h80000000, 4'd3},  // R3
    '{4'd2, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b1, 3'd1, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h85000000, 4'd4},  // R4
    '{4'd3, 32'h5, 32'h0, 16'hFFFB, 1'b0, 3'd2, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h85400000, 4'd5},      // R5
    '{4'd4, 32'h5, 32'h0, 16'hFFFB, 1'b0, 3'd3, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h85480000, 4'd5},      // R5
    '{4'd1, 32'h7, 32'h7, 16'h0, 1'b1, 3'd7, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h85480003, 4'd2},         // R2
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd30, 5'd29, 3'd0, 8'h00, 32'h85480007, 4'd7},       // R7 AND
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd1, 5'd0, 3'd4, 8'h00, 32'h05480007, 4'd7},         // R7 NOR
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd5, 5'd4, 5'd8, 3'd6, 8'h00, 32'h05C80007, 4'd7},         // R7 ANDC
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd1, 5'd3, 5'd28, 3'd7, 8'h00, 32'h05C8000F, 4'd7},        // R7 ORC
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd31, 5'd30, 5'd7, 3'd3, 8'h00, 32'h04C8000F, 4'd6},       // R6 XOR
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd4, 5'd0, 5'd16, 3'd5, 8'h00, 32'h04C8800F, 4'd7},        // R7 EQV
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd16, 5'd28, 5'd5, 3'd2, 8'h00, 32'h00C8800F, 4'd7},       // R7 NAND
    '{4'd5, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd1, 5'd2, 5'd9, 3'd1, 8'h00, 32'h0088800F, 4'd6},         // R6 OR
    '{4'd6, 32'h0, 32'h0, 16'h0, 1'b0, 3'd5, 3'd2, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h0088880F, 4'd8},         // R8
    '{4'd6, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd7, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'hF088880F, 4'd8},         // R8
    '{4'd7, 32'h12345678, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h81, 32'h10888808, 4'd9},  // R9
    '{4'd7, 32'hFFFFFFFF, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'h10888808, 4'd9},  // R9
    '{4'd0, 32'hFFFFFFFF, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'hFF, 32'h10888808, 4'd10}, // R10
    '{4'd7, 32'hDEADBEEF, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'hFF, 32'hDEADBEEF, 4'd9},  // R9
    '{4'd3, 32'h80000000, 32'h0, 16'h7FFF, 1'b0, 3'd4, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'hDEAD8EEF, 4'd5}, // R5
    '{4'd4, 32'h0000FFFF, 32'h0, 16'hFFFF, 1'b1, 3'd6, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'hDEAD8E3F, 4'd5}, // R5
    '{4'd2, 32'h0, 32'h80000000, 16'h0, 1'b0, 3'd7, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'hDEAD8E38, 4'd4},  // R4
    '{4'd1, 32'h0, 32'h80000000, 16'h0, 1'b0, 3'd7, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'h00, 32'hDEAD8E34, 4'd3},  // R3
    '{4'd12, 32'h0, 32'h0, 16'h0, 1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 8'hFF, 32'hDEAD8E34, 4'd10}       // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cr_q=%08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic valid);
    cmd_valid = valid;
    cmd_op = v.op; opnd_a = v.a; opnd_b = v.b; imm16 = v.imm; so_in = v.so;
    fld_dst = v.dst; fld_src = v.src; bit_a = v.ba; bit_b = v.bb; bit_t = v.bt;
    bool_fn = v.fn; fld_mask = v.mask;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    vec_t d;
    repeat (3) @(negedge clk);
    check("R1 reset value", cr_q, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", cr_q, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), cr_q, VECS[i].exp);
    end

    // R10: valid low with a full masked write pending
    d = '0; d.op = 4'd7; d.a = 32'h0; d.mask = 8'hFF;
    drive(d, 1'b0);
    check("R10 idle masked write", cr_q, 32'hDEAD8E34);

    // R8: copy field 3 onto itself
    d = '0; d.op = 4'd6; d.dst = 3'd3; d.src = 3'd3;
    drive(d, 1'b1);
    check("R8 self copy", cr_q, 32'hDEAD8E34);

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", cr_q, 32'h0);

    // R5: signed immediate -1 against -1 gives equal in field 0
    d = '0; d.op = 4'd3; d.a = 32'hFFFFFFFF; d.imm = 16'hFFFF; d.dst = 3'd0;
    drive(d, 1'b1);
    check("R5 signed imm equal", cr_q, 32'h20000000);

    // R5: unsigned immediate 0xFFFF against all-ones gives greater
    d = '0; d.op = 4'd4; d.a = 32'hFFFFFFFF; d.imm = 16'hFFFF; d.dst = 3'd1;
    drive(d, 1'b1);
    check("R5 unsigned imm greater", cr_q, 32'h24000000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule